// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block brings an SDRAM array out of reset before the memory is opened to host traffic. One start pulse sets it running. It first unlocks a system control register and toggles a reset bit in it. It then sends the memory array a precharge-all command, eight auto-refresh commands and a mode-set command. Last, it sets an enable bit in a DRAM configuration register by reading the register, setting the bit and writing it back.

All register traffic goes through one simple port. The port has a shared address, write data, read data, a one-cycle write strobe, a one-cycle read strobe and a common acknowledge. After each memory command the block samples a busy input. It waits only for a bounded number of samples, so a device whose busy flag never clears cannot hang it. Instead it records the problem in a sticky timeout flag and carries on. A one-cycle done pulse marks the end of the run.

Top module: `sdramInitSeq`

## Requirements
- R1: After reset, `regWrStb`, `regRdStb`, `done` and `timeout` are all 0. No register access happens until `start` is pulsed.
- R2: The first access of a run writes 0xA5 to the system control register (address 0x78).
- R3: Ten reset pulses follow, as twenty writes to address 0x78 alternating 0x25 (bit 7 low) and 0xA5 (bit 7 high). Then one write of 0xE5 sets bits 6 and 5.
- R4: Precharge is a write of 0x0400 to the address register (0x60), then a write of 0x00BF to the command register (0x62), then a busy poll.
- R5: Eight auto-refresh commands follow, each a write of 0x00DF to 0x62 followed by its own busy poll.
- R6: Mode set is a write of 0x0020 to 0x60, then a write of 0x00FF to 0x62, then a busy poll.
- R7: A busy poll samples `busyIn` once per clock, starting on the second rising edge after the edge that takes in the command's acknowledge. The run moves on at the first sample that reads 0. If 101 samples in a row read 1, the poll gives up, sets `timeout`, and the run moves on. With 100 busy samples the poll does not time out.
- R8: The last two accesses are a read of the configuration register (0x64) and a write to 0x64. The write carries the read data with bit 25 set.
- R9: Only one access is in flight at a time. A strobe lasts one cycle, the write and read strobes are never high together, and no new strobe comes before the previous access is acknowledged. A run makes exactly 36 accesses.
- R10: `done` is high for exactly one cycle at the end of a run. `timeout` is cleared when a run starts and holds its value after `done`.
- R11: A `start` pulse during a run has no effect on the access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| regWrStb | output | 1 | One-cycle write request |
| regRdStb | output | 1 | One-cycle read request |
| regAddr | output | 8 | Register address for the current access |
| regWrData | output | 32 | Write data |
| regRdData | input | 32 | Read data, valid with `regAck` of a read |
| regAck | input | 1 | Acknowledge of the outstanding access |
| busyIn | input | 1 | Command-busy status of the SDRAM controller |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout | output | 1 | Sticky flag: some busy poll gave up |

## Verification
A strobe appears in the cycle after the edge that decides it, so the bench observes strobes and data at falling edges. It raises the acknowledge a set number of falling edges later, and that acknowledge is taken in at the next rising edge. Busy samples start two rising edges after the acknowledge of a command. The bench therefore holds busy high for a counted number of falling edges from that acknowledge: 102 gives 100 busy samples and no timeout, and 103 gives 101 busy samples and a timeout. Done and timeout are read at falling edges during and after the run, so the one-cycle pulse is counted exactly and the sticky flag is read once it has settled.

// File: rtl/sdramInitPkg.sv
package sdramInitPkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_POLL  = 2'd2,
    OP_END   = 2'd3
  } opKind_t;

  typedef struct packed {
    logic clearRun;     // new run: rewind step index, clear timeout
    logic advance;      // current step finished
    logic captureRd;    // latch read data
    logic flagTimeout;  // a poll gave up
  } seqCtl_t;

  localparam logic [7:0] CTRL_KEY      = 8'hA5;
  localparam logic [7:0] CTRL_RST_BIT  = 8'h80;
  localparam logic [7:0] CTRL_LOCK_BIT = 8'h60;

  localparam logic [15:0] MA_PRECHARGE = 16'h0400;
  localparam logic [15:0] MA_MODE      = 16'h0020;
  localparam logic [15:0] CMD_PRECHG   = 16'h00BF;
  localparam logic [15:0] CMD_REFRESH  = 16'h00DF;
  localparam logic [15:0] CMD_MODESET  = 16'h00FF;

endpackage

// File: rtl/initSeqPath.sv
module initSeqPath
  import sdramInitPkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SYS_ADDR  = 'h78,
  parameter int unsigned MA_ADDR   = 'h60,
  parameter int unsigned CMD_ADDR  = 'h62,
  parameter int unsigned CFG_ADDR  = 'h64,
  parameter int unsigned PULSES    = 10,
  parameter int unsigned REFRESHES = 8,
  parameter int unsigned CFG_BIT   = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [DATA_W-1:0] rdData,
  output opKind_t           op,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wrData,
  output logic              timeoutFlag
);

  localparam int unsigned STEP_LOCK     = 1 + 2 * PULSES;
  localparam int unsigned STEP_PRE_MA   = STEP_LOCK + 1;
  localparam int unsigned STEP_PRE_CMD  = STEP_PRE_MA + 1;
  localparam int unsigned STEP_PRE_POLL = STEP_PRE_CMD + 1;
  localparam int unsigned STEP_REF0     = STEP_PRE_POLL + 1;
  localparam int unsigned STEP_MODE_MA  = STEP_REF0 + 2 * REFRESHES;
  localparam int unsigned STEP_MODE_CMD = STEP_MODE_MA + 1;
  localparam int unsigned STEP_MODE_PL  = STEP_MODE_CMD + 1;
  localparam int unsigned STEP_CFG_RD   = STEP_MODE_PL + 1;
  localparam int unsigned STEP_CFG_WR   = STEP_CFG_RD + 1;
  localparam int unsigned STEP_END      = STEP_CFG_WR + 1;
  localparam int unsigned STEP_W        = $clog2(STEP_END + 1);

  logic [STEP_W-1:0] stepIdx;
  logic [DATA_W-1:0] cfgShadow;
  logic [31:0]       idxWide;
  logic [31:0]       refOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx     <= '0;
      cfgShadow   <= '0;
      timeoutFlag <= 1'b0;
    end else begin
      if (ctl.clearRun)         stepIdx <= '0;
      else if (ctl.advance)     stepIdx <= stepIdx + 1'b1;
      if (ctl.captureRd)        cfgShadow <= rdData;
      if (ctl.clearRun)         timeoutFlag <= 1'b0;
      else if (ctl.flagTimeout) timeoutFlag <= 1'b1;
    end
  end

  assign idxWide   = {{(32 - STEP_W){1'b0}}, stepIdx};
  assign refOffset = idxWide - STEP_REF0;

  always_comb begin
    op     = OP_WRITE;
    addr   = ADDR_W'(SYS_ADDR);
    wrData = '0;
    if (idxWide == 0) begin
      wrData = DATA_W'(CTRL_KEY);
    end else if (idxWide < STEP_LOCK) begin
      wrData = idxWide[0] ? DATA_W'(CTRL_KEY & ~CTRL_RST_BIT)
                          : DATA_W'(CTRL_KEY | CTRL_RST_BIT);
    end else if (idxWide == STEP_LOCK) begin
      wrData = DATA_W'(CTRL_KEY | CTRL_RST_BIT | CTRL_LOCK_BIT);
    end else if (idxWide == STEP_PRE_MA) begin
      addr   = ADDR_W'(MA_ADDR);
      wrData = DATA_W'(MA_PRECHARGE);
    end else if (idxWide == STEP_PRE_CMD) begin
      addr   = ADDR_W'(CMD_ADDR);
      wrData = DATA_W'(CMD_PRECHG);
    end else if (idxWide == STEP_PRE_POLL) begin
      op   = OP_POLL;
      addr = ADDR_W'(CMD_ADDR);
    end else if (idxWide < STEP_MODE_MA) begin
      addr   = ADDR_W'(CMD_ADDR);
      wrData = DATA_W'(CMD_REFRESH);
      if (refOffset[0]) op = OP_POLL;
    end else if (idxWide == STEP_MODE_MA) begin
      addr   = ADDR_W'(MA_ADDR);
      wrData = DATA_W'(MA_MODE);
    end else if (idxWide == STEP_MODE_CMD) begin
      addr   = ADDR_W'(CMD_ADDR);
      wrData = DATA_W'(CMD_MODESET);
    end else if (idxWide == STEP_MODE_PL) begin
      op   = OP_POLL;
      addr = ADDR_W'(CMD_ADDR);
    end else if (idxWide == STEP_CFG_RD) begin
      op   = OP_READ;
      addr = ADDR_W'(CFG_ADDR);
    end else if (idxWide == STEP_CFG_WR) begin
      addr   = ADDR_W'(CFG_ADDR);
      wrData = cfgShadow | (DATA_W'(1) << CFG_BIT);
    end else begin
      op = OP_END;
    end
  end

  // R10
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !ctl.clearRun) |=> timeoutFlag);

  // R9
  step_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !ctl.clearRun) |=> $stable(stepIdx));

endmodule

// File: rtl/initSeqCtrl.sv
module initSeqCtrl
  import sdramInitPkg::*;
#(
  parameter int unsigned MAX_POLLS = 101
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    ack,
  input  logic    busyIn,
  input  opKind_t op,
  output seqCtl_t ctl,
  output logic    wrStb,
  output logic    rdStb,
  output logic    done
);

  localparam int unsigned PW = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_DISPATCH, S_ISSUE_WR, S_WAIT_WR,
    S_ISSUE_RD, S_WAIT_RD, S_POLL, S_DONE
  } state_t;

  state_t        state, stateNext;
  logic [PW-1:0] pollCnt, pollCntNext;
  logic          running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pollCnt <= '0;
    end else begin
      state   <= stateNext;
      pollCnt <= pollCntNext;
    end
  end

  always_comb begin
    stateNext   = state;
    pollCntNext = pollCnt;
    ctl         = '0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.clearRun = 1'b1;
        stateNext    = S_DISPATCH;
      end
      S_DISPATCH: begin
        pollCntNext = '0;
        unique case (op)
          OP_WRITE: stateNext = S_ISSUE_WR;
          OP_READ:  stateNext = S_ISSUE_RD;
          OP_POLL:  stateNext = S_POLL;
          default:  stateNext = S_DONE;
        endcase
      end
      S_ISSUE_WR: stateNext = S_WAIT_WR;
      S_WAIT_WR: if (ack) begin
        ctl.advance = 1'b1;
        stateNext   = S_DISPATCH;
      end
      S_ISSUE_RD: stateNext = S_WAIT_RD;
      S_WAIT_RD: if (ack) begin
        ctl.advance   = 1'b1;
        ctl.captureRd = 1'b1;
        stateNext     = S_DISPATCH;
      end
      S_POLL: begin
        if (!busyIn) begin
          ctl.advance = 1'b1;
          stateNext   = S_DISPATCH;
        end else if (pollCnt == PW'(MAX_POLLS - 1)) begin
          ctl.advance     = 1'b1;
          ctl.flagTimeout = 1'b1;
          stateNext       = S_DISPATCH;
        end else begin
          pollCntNext = pollCnt + 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign wrStb   = (state == S_ISSUE_WR);
  assign rdStb   = (state == S_ISSUE_RD);
  assign done    = (state == S_DONE);
  assign running = (state != S_IDLE);

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb || rdStb) |=> !(wrStb || rdStb));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && start && !done) |=> running);

  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= PW'(MAX_POLLS - 1));

endmodule

// File: rtl/sdramInitSeq.sv
module sdramInitSeq
  import sdramInitPkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SYS_ADDR  = 'h78,
  parameter int unsigned MA_ADDR   = 'h60,
  parameter int unsigned CMD_ADDR  = 'h62,
  parameter int unsigned CFG_ADDR  = 'h64,
  parameter int unsigned PULSES    = 10,
  parameter int unsigned REFRESHES = 8,
  parameter int unsigned CFG_BIT   = 25,
  parameter int unsigned MAX_POLLS = 101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              regWrStb,
  output logic              regRdStb,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  input  logic              regAck,
  input  logic              busyIn,
  output logic              done,
  output logic              timeout
);

  seqCtl_t ctl;
  opKind_t op;

  initSeqCtrl #(.MAX_POLLS(MAX_POLLS)) ctrlInst (
    .clk(clk), .rstN(rstN), .start(start), .ack(regAck), .busyIn(busyIn),
    .op(op), .ctl(ctl), .wrStb(regWrStb), .rdStb(regRdStb), .done(done)
  );

  initSeqPath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYS_ADDR(SYS_ADDR), .MA_ADDR(MA_ADDR),
    .CMD_ADDR(CMD_ADDR), .CFG_ADDR(CFG_ADDR), .PULSES(PULSES),
    .REFRESHES(REFRESHES), .CFG_BIT(CFG_BIT)
  ) pathInst (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdData(regRdData), .op(op),
    .addr(regAddr), .wrData(regWrData), .timeoutFlag(timeout)
  );

endmodule

// File: tb/sdramInitSeq_test.sv
module sdramInitSeq_test;

  localparam logic [7:0] A_SYS = 8'h78, A_MA = 8'h60, A_CMD = 8'h62, A_CFG = 8'h64;
  localparam int NUM_TX = 36;

  typedef struct packed {
    int unsigned ackDly;
    int unsigned hold;
    bit          stuck;
    bit          midStart;
    bit          expTo;
    logic [31:0] cfg;
  } row_t;

  localparam row_t ROWS [5] = '{
    '{1, 0,   1'b0, 1'b0, 1'b0, 32'h0000_0000},
    '{3, 102, 1'b0, 1'b1, 1'b0, 32'h1234_5678},
    '{1, 103, 1'b0, 1'b0, 1'b1, 32'hFDFF_FFFF},
    '{2, 0,   1'b1, 1'b0, 1'b1, 32'h0200_0001},
    '{1, 5,   1'b0, 1'b0, 1'b0, 32'hA5A5_0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        regWrStb, regRdStb, regAck = 1'b0, busyIn = 1'b0, done, timeout;
  logic [7:0]  regAddr;
  logic [31:0] regWrData, regRdData = '0;

  always #5 clk = ~clk;

  sdramInitSeq uut (
    .clk(clk), .rstN(rstN), .start(start), .regWrStb(regWrStb),
    .regRdStb(regRdStb), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .regAck(regAck), .busyIn(busyIn),
    .done(done), .timeout(timeout)
  );

  int total = 0, bad = 0;
  logic [40:0] txLog [64];
  int nTx, doneCnt;
  bit dual;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [40:0] expTx(input int i, input logic [31:0] cfg);
    if (i == 0)       return {1'b0, A_SYS, 32'hA5};
    else if (i <= 20) return {1'b0, A_SYS, (i % 2 == 1) ? 32'h25 : 32'hA5};
    else if (i == 21) return {1'b0, A_SYS, 32'hE5};
    else if (i == 22) return {1'b0, A_MA, 32'h0400};
    else if (i == 23) return {1'b0, A_CMD, 32'h00BF};
    else if (i <= 31) return {1'b0, A_CMD, 32'h00DF};
    else if (i == 32) return {1'b0, A_MA, 32'h0020};
    else if (i == 33) return {1'b0, A_CMD, 32'h00FF};
    else if (i == 34) return {1'b1, A_CFG, 32'h0};
    else              return {1'b0, A_CFG, cfg | 32'h0200_0000};
  endfunction

  function automatic string segTag(input int i);
    if (i == 0)       return "R2 unlock write";
    else if (i <= 21) return "R3 reset pulses";
    else if (i <= 23) return "R4 precharge";
    else if (i <= 31) return "R5 refresh";
    else if (i <= 33) return "R6 mode set";
    else              return "R8 config read-modify-write";
  endfunction

  task automatic runSeq(input row_t r);
    int pend = 0;
    bit pendRd = 1'b0, pendCmd = 1'b0;
    int busyLeft = 0;
    int guard = 0;
    int tail = -1;
    nTx = 0; doneCnt = 0; dual = 1'b0;
    regRdData = r.cfg;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (tail != 0 && guard < 30000) begin
      @(negedge clk);
      guard++;
      regAck = 1'b0;
      start  = 1'b0;
      if (busyLeft > 0) busyLeft--;
      busyIn = r.stuck || (busyLeft > 0);
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          regAck = 1'b1;
          if (pendCmd) begin
            busyLeft = r.hold;
            busyIn = r.stuck || (busyLeft > 0);
          end
        end
      end
      if (regWrStb && regRdStb) dual = 1'b1;
      if (regWrStb || regRdStb) begin
        if (nTx < 64) txLog[nTx] = {regRdStb, regAddr, regRdStb ? 32'h0 : regWrData};
        nTx++;
        pend    = r.ackDly;
        pendRd  = regRdStb;
        pendCmd = regWrStb && (regAddr == A_CMD);
        // R11: restart attempt while running
        if (r.midStart && nTx == 10) start = 1'b1;
      end
      if (done) doneCnt++;
      if (tail > 0) tail--;
      else if (done && tail < 0) tail = 3;
    end
    if (pendRd) pendRd = 1'b0;
    busyIn = 1'b0;
    start  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R10 actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int strobes;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(regWrStb == 1'b0 && regRdStb == 1'b0, "R1 strobes in reset", {regWrStb, regRdStb}, 0);
    check(done == 1'b0 && timeout == 1'b0, "R1 done/timeout in reset", {done, timeout}, 0);
    rstN = 1'b1;
    strobes = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (regWrStb || regRdStb || done) strobes++;
    end
    check(strobes == 0, "R1 idle without start", strobes, 0);

    for (int row = 0; row < 5; row++) begin
      runSeq(ROWS[row]);
      check(nTx == NUM_TX, ROWS[row].midStart ? "R11 access count" : "R9 access count", nTx, NUM_TX);
      for (int i = 0; i < NUM_TX && i < nTx; i++)
        check(txLog[i] == expTx(i, ROWS[row].cfg), segTag(i), txLog[i], expTx(i, ROWS[row].cfg));
      check(!dual, "R9 strobes exclusive", dual, 0);
      check(doneCnt == 1, "R10 done pulse width", doneCnt, 1);
      check(timeout == ROWS[row].expTo, "R7 timeout flag", timeout, ROWS[row].expTo);
    end

    // R10: flag stays clear while idle after a clean run
    repeat (10) @(negedge clk);
    check(timeout == 1'b0 && done == 1'b0, "R10 idle after run", {done, timeout}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule